// File: doc/BRIEF.md
# IBI Chunk Pool Tracker

This block is the hardware half of an in-band-interrupt receive path. Payload bytes arrive one per cycle, each marked as the first byte of a payload, the last byte, or carrying an error, with the target address of the interrupting device. Each accepted byte is written into a circular pool of equal-sized data chunks. The chunk size is a power of two selected by a 3-bit code. A status word describing each group of chunks is written into a circular status ring that software drains.

Software owns the ring read side. It moves a dequeue index to free status slots, and it returns consumed chunks by pulsing a credit-return count. The block counts chunks it has opened and not yet been given back. When the next byte would need a fresh chunk and none is free, it stops accepting bytes and raises a stall flag. It raises an interrupt pulse with every status write and a level interrupt while the status ring has no free slot.

Top module: `ibi_chunk_pool`

## Requirements
- R1: With chunk code n (0 to 6), a chunk holds 2^(n+2) bytes. An accepted byte is written on the cycle after acceptance at pool byte address chunk_index * 2^(n+2) + offset_in_chunk, with the byte on dwr_data.
- R2: The chunk index moves on by one after the byte that fills a chunk or ends a payload. It goes back to 0 after index cfg_chunk_total-1, so a payload may run across that wrap. The next payload always starts at offset 0 of a new chunk.
- R3: Each byte written at offset 0 of a chunk uses up one credit. A pulse on credit_ret_valid gives back credit_ret_cnt credits. When no credit remains and the next byte would open a chunk, stall is high and in_ready is low. A byte that continues a partly filled chunk is still accepted with zero credit.
- R4: The last byte of a payload posts a status word with bit 31 (last) = 1. Bits 14:0 hold the byte count of the final group. Bits 22:15 hold the number of chunks that group touched.
- R5: A group is closed early when a byte fills a chunk, the group has reached GRP_MAX chunks, and the byte is not the last one. The block then posts a status word with last = 0, chunk count GRP_MAX and length field 0.
- R6: Bit 30 (error) of a status word is 1 if any byte of that group was flagged in_err. The flag clears for the next group.
- R7: Bits 29:23 of every status word of a payload hold the target address given with that payload's first byte.
- R8: Status words are written to ring index swr_idx. The index starts at 0 and moves on by one per word, going back to 0 after cfg_ring_entries-1.
- R9: irq_ibi_ready is a one-cycle pulse in the same cycle as each status write, and only then.
- R10: irq_ring_full is high, and in_ready low, whenever the write index plus one (modulo the ring size) equals sw_deq_ptr.
- R11: After reset, in_ready is high, and stall, dwr_valid, swr_valid, irq_ibi_ready and irq_ring_full are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_chunk_code | input | 3 | Chunk size code n, size 2^(n+2) bytes |
| cfg_chunk_total | input | IDX_W | Number of chunks in the pool |
| cfg_ring_entries | input | PTR_W | Number of status ring slots |
| sw_deq_ptr | input | PTR_W | Software dequeue index of the status ring |
| credit_ret_valid | input | 1 | Chunk return strobe |
| credit_ret_cnt | input | IDX_W | Number of chunks returned |
| in_valid | input | 1 | Payload byte present |
| in_start | input | 1 | First byte of a payload |
| in_last | input | 1 | Last byte of a payload |
| in_err | input | 1 | Byte carries an error |
| in_taddr | input | 7 | Target address (sampled with in_start) |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Byte is accepted this cycle if valid |
| stall | output | 1 | No chunk credit for the next chunk |
| dwr_valid | output | 1 | Chunk data write strobe |
| dwr_addr | output | IDX_W+OFF_W | Pool byte address |
| dwr_data | output | 8 | Byte to write |
| swr_valid | output | 1 | Status write strobe |
| swr_idx | output | PTR_W | Status ring slot |
| swr_word | output | 32 | Status word |
| irq_ibi_ready | output | 1 | Status posted interrupt pulse |
| irq_ring_full | output | 1 | Status ring full interrupt level |

## Verification
The assertions take for granted several things about the block's inputs. Configuration stays fixed while a payload is in flight. A credit return never gives back more chunks than are outstanding. in_start marks the first byte of every payload. The ring has at least two slots. The stimulus keeps to these rules. It changes the chunk code only between payloads. It returns at most the chunk count its own model holds as outstanding. It moves the dequeue index forward by no more than the number of pending status words. It always sets start on the first byte. Random payload lengths, error flags and addresses are mixed with directed runs that drain the credit inside a chunk and fill the ring.

// File: rtl/ibi_pool_pkg.sv
package ibi_pool_pkg;

    localparam int TADDR_W = 7;
    localparam int CHUNKS_W = 8;
    localparam int LEN_W = 15;

    // Status word layout, bit 31 down to bit 0
    typedef struct packed {
        logic                last;
        logic                err;
        logic [TADDR_W-1:0]  taddr;
        logic [CHUNKS_W-1:0] chunks;
        logic [LEN_W-1:0]    len;
    } ibi_status_t;

endpackage

// File: rtl/ibi_chunk_walker.sv
module ibi_chunk_walker #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             cfg_code,
    input  logic [IDX_W-1:0]       cfg_total,
    input  logic                   step,
    input  logic                   close,
    output logic                   open_req,
    output logic                   fill,
    output logic [IDX_W+OFF_W-1:0] pool_addr
);
    localparam int AW = IDX_W + OFF_W;
    localparam logic [2:0] MAX_CODE = 3'(OFF_W - 2);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } walk_t;

    walk_t s_d, s_q;
    logic [2:0]       code_eff;
    logic [3:0]       shift;
    logic [OFF_W-1:0] size_m1;

    always_comb begin
        code_eff  = (cfg_code > MAX_CODE) ? MAX_CODE : cfg_code;
        shift     = {1'b0, code_eff} + 4'd2;
        size_m1   = OFF_W'((AW'(1) << shift) - AW'(1));
        open_req  = (s_q.off == '0);
        fill      = (s_q.off == size_m1);
        pool_addr = (AW'(s_q.idx) << shift) | AW'(s_q.off);

        s_d = s_q;
        if (step) begin
            if (fill || close) begin
                s_d.off = '0;
                s_d.idx = (IDX_W'(s_q.idx + 1'b1) == cfg_total) ? '0 : IDX_W'(s_q.idx + 1'b1);
            end else begin
                s_d.off = s_q.off + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CHUNK_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx < cfg_total); // R2
    AST_OFF_IN_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.off <= size_m1); // R1

endmodule

// File: rtl/ibi_credit_pool.sv
module ibi_credit_pool #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_total,
    input  logic             take,
    input  logic             ret_valid,
    input  logic [CNT_W-1:0] ret_cnt,
    output logic             no_credit
);
    typedef struct packed {
        logic [CNT_W-1:0] used;
    } credit_t;

    credit_t s_d, s_q;

    always_comb begin
        no_credit = (s_q.used >= cfg_total);
        s_d = s_q;
        s_d.used = s_q.used + CNT_W'(take) - (ret_valid ? ret_cnt : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.used <= cfg_total); // R3
    AST_TAKE_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !no_credit); // R3
    AST_RETURN_NOT_EXCESS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ({1'b0, ret_cnt} <= {1'b0, s_q.used} + (CNT_W+1)'(take))); // R3

endmodule

// File: rtl/ibi_status_ring.sv
module ibi_status_ring #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] cfg_entries,
    input  logic [PTR_W-1:0] sw_deq,
    input  logic             post,
    output logic [PTR_W-1:0] enq,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0] enq;
    } ring_t;

    ring_t s_d, s_q;
    logic [PTR_W-1:0] nxt;

    always_comb begin
        nxt  = (PTR_W'(s_q.enq + 1'b1) == cfg_entries) ? '0 : PTR_W'(s_q.enq + 1'b1);
        full = (nxt == sw_deq);
        enq  = s_q.enq;
        s_d  = s_q;
        if (post) s_d.enq = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_NO_POST_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        post |-> !full); // R10
    AST_ENQ_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.enq < cfg_entries); // R8
    AST_ENQ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> s_q.enq != $past(s_q.enq)); // R8

endmodule

// File: rtl/ibi_chunk_pool.sv
module ibi_chunk_pool
    import ibi_pool_pkg::*;
#(
    parameter int IDX_W   = 10,
    parameter int OFF_W   = 8,
    parameter int PTR_W   = 8,
    parameter int GRP_MAX = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             cfg_chunk_code,
    input  logic [IDX_W-1:0]       cfg_chunk_total,
    input  logic [PTR_W-1:0]       cfg_ring_entries,
    input  logic [PTR_W-1:0]       sw_deq_ptr,
    input  logic                   credit_ret_valid,
    input  logic [IDX_W-1:0]       credit_ret_cnt,
    input  logic                   in_valid,
    input  logic                   in_start,
    input  logic                   in_last,
    input  logic                   in_err,
    input  logic [6:0]             in_taddr,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic                   stall,
    output logic                   dwr_valid,
    output logic [IDX_W+OFF_W-1:0] dwr_addr,
    output logic [7:0]             dwr_data,
    output logic                   swr_valid,
    output logic [PTR_W-1:0]       swr_idx,
    output logic [31:0]            swr_word,
    output logic                   irq_ibi_ready,
    output logic                   irq_ring_full
);
    localparam int AW = IDX_W + OFF_W;
    localparam logic [CHUNKS_W-1:0] GRP_LIM = CHUNKS_W'(GRP_MAX);

    typedef struct packed {
        logic [CHUNKS_W-1:0] g_chunks;
        logic [LEN_W-1:0]    g_len;
        logic                g_err;
        logic [TADDR_W-1:0]  taddr;
        logic                dv;
        logic [AW-1:0]       da;
        logic [7:0]          dd;
        logic                sv;
        logic [PTR_W-1:0]    si;
        ibi_status_t         sw;
        logic                irq;
    } top_t;

    top_t s_d, s_q;

    logic           open_req, fill, no_credit, ring_full, accept, post, post_split;
    logic [AW-1:0]  pool_addr;
    logic [PTR_W-1:0] enq;
    logic [CHUNKS_W-1:0] new_chunks;
    logic [LEN_W-1:0]    new_len;
    logic                new_err;
    logic [TADDR_W-1:0]  new_taddr;

    ibi_chunk_walker #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .cfg_code(cfg_chunk_code), .cfg_total(cfg_chunk_total),
        .step(accept), .close(in_last), .open_req(open_req), .fill(fill), .pool_addr(pool_addr)
    );

    ibi_credit_pool #(.CNT_W(IDX_W)) u_credit (
        .clk(clk), .rst_n(rst_n), .cfg_total(cfg_chunk_total), .take(accept && open_req),
        .ret_valid(credit_ret_valid), .ret_cnt(credit_ret_cnt), .no_credit(no_credit)
    );

    ibi_status_ring #(.PTR_W(PTR_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .cfg_entries(cfg_ring_entries), .sw_deq(sw_deq_ptr),
        .post(post), .enq(enq), .full(ring_full)
    );

    always_comb begin
        stall      = open_req && no_credit;
        in_ready   = !ring_full && !stall;
        accept     = in_valid && in_ready;
        new_chunks = (in_start ? '0 : s_q.g_chunks) + CHUNKS_W'(open_req);
        new_len    = (in_start ? '0 : s_q.g_len) + 1'b1;
        new_err    = (in_start ? 1'b0 : s_q.g_err) | in_err;
        new_taddr  = in_start ? in_taddr : s_q.taddr;
        post_split = !in_last && fill && (new_chunks == GRP_LIM);
        post       = accept && (in_last || post_split);

        s_d     = s_q;
        s_d.dv  = 1'b0;
        s_d.sv  = 1'b0;
        s_d.irq = 1'b0;
        if (accept) begin
            s_d.dv       = 1'b1;
            s_d.da       = pool_addr;
            s_d.dd       = in_data;
            s_d.g_chunks = new_chunks;
            s_d.g_len    = new_len;
            s_d.g_err    = new_err;
            s_d.taddr    = new_taddr;
            if (post) begin
                s_d.sv        = 1'b1;
                s_d.irq       = 1'b1;
                s_d.si        = enq;
                s_d.sw.last   = in_last;
                s_d.sw.err    = new_err;
                s_d.sw.taddr  = new_taddr;
                s_d.sw.chunks = new_chunks;
                s_d.sw.len    = in_last ? new_len : '0;
                s_d.g_chunks  = '0;
                s_d.g_len     = '0;
                s_d.g_err     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dwr_valid     = s_q.dv;
    assign dwr_addr      = s_q.da;
    assign dwr_data      = s_q.dd;
    assign swr_valid     = s_q.sv;
    assign swr_idx       = s_q.si;
    assign swr_word      = s_q.sw;
    assign irq_ibi_ready = s_q.irq;
    assign irq_ring_full = ring_full;

    AST_ENTRY_HAS_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        swr_valid |-> s_q.sw.chunks != '0); // R4
    AST_SPLIT_FULL_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (swr_valid && !s_q.sw.last) |-> (s_q.sw.chunks == GRP_LIM && s_q.sw.len == '0)); // R5
    AST_IRQ_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ibi_ready == swr_valid); // R9
    AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && in_valid) |=> !($past(open_req) && dwr_valid && !$past(in_ready))); // R3

endmodule

// File: tb/sim_ibi_chunk_pool.sv
`timescale 1ns/1ps
module sim_ibi_chunk_pool;
    localparam int TOTAL = 10;
    localparam int RING  = 6;
    localparam int GRP   = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic [2:0] code;
    logic [7:0] sw_deq;
    logic cr_v; logic [9:0] cr_n;
    logic iv, ist, ilast, ierr; logic [6:0] ia; logic [7:0] id;
    logic in_ready, stall, dwr_valid, swr_valid, irq_rdy, irq_full;
    logic [17:0] dwr_addr; logic [7:0] dwr_data, swr_idx; logic [31:0] swr_word;

    ibi_chunk_pool u0 (
        .clk(clk), .rst_n(rst_n), .cfg_chunk_code(code), .cfg_chunk_total(10'(TOTAL)),
        .cfg_ring_entries(8'(RING)), .sw_deq_ptr(sw_deq), .credit_ret_valid(cr_v),
        .credit_ret_cnt(cr_n), .in_valid(iv), .in_start(ist), .in_last(ilast), .in_err(ierr),
        .in_taddr(ia), .in_data(id), .in_ready(in_ready), .stall(stall),
        .dwr_valid(dwr_valid), .dwr_addr(dwr_addr), .dwr_data(dwr_data),
        .swr_valid(swr_valid), .swr_idx(swr_idx), .swr_word(swr_word),
        .irq_ibi_ready(irq_rdy), .irq_ring_full(irq_full)
    );

    int n_chk = 0, n_fail = 0;
    int m_chunk = 0, m_off = 0, m_used = 0, m_enq = 0;
    int g_chunks = 0, g_len = 0, g_err = 0, g_addr = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(int l, int e, int a, int c, int n);
        logic [31:0] w;
        w = {l[0], e[0], a[6:0], c[7:0], n[14:0]};
        return w;
    endfunction

    function automatic bit m_full();
        return ((m_enq + 1) % RING) == sw_deq;
    endfunction

    // Called at negedge + 0.5; returns at negedge + 0.5
    task automatic send(input bit st, input bit last, input bit err, input int a,
                        input int d, output bit acc);
        bit exp_rdy, open, fill, split, post;
        int sz, e_addr, nc, nl, ne, na;
        logic [31:0] e_word;
        int e_idx;
        iv = 1'b1; ist = st; ilast = last; ierr = err; ia = 7'(a); id = 8'(d);
        #0.5;
        open = (m_off == 0);
        exp_rdy = !m_full() && !(open && m_used >= TOTAL);
        chk("R3", "stall", stall, open && m_used >= TOTAL);
        chk("R3", "in_ready", in_ready, exp_rdy);
        chk("R10", "irq_ring_full", irq_full, m_full());
        if (!exp_rdy) begin
            iv = 1'b0; acc = 1'b0;
            @(negedge clk); #0.5;
            return;
        end
        sz = 4 << code;
        e_addr = m_chunk * sz + m_off;
        fill = (m_off == sz - 1);
        nc = (st ? 0 : g_chunks) + (open ? 1 : 0);
        nl = (st ? 0 : g_len) + 1;
        ne = (st ? 0 : g_err) | err;
        na = st ? a : g_addr;
        split = !last && fill && (nc == GRP);
        post = last || split;
        e_word = mk_word(last, ne, na, nc, last ? nl : 0);
        e_idx = m_enq;
        m_used += open ? 1 : 0;
        if (fill || last) begin
            m_off = 0; m_chunk = (m_chunk + 1 == TOTAL) ? 0 : m_chunk + 1;
        end else m_off++;
        if (post) begin
            m_enq = (m_enq + 1) % RING; g_chunks = 0; g_len = 0; g_err = 0;
        end else begin
            g_chunks = nc; g_len = nl; g_err = ne;
        end
        g_addr = na;
        @(negedge clk);
        iv = 1'b0;
        chk("R1", "dwr_valid", dwr_valid, 1);
        chk("R2", "dwr_addr", dwr_addr, e_addr);
        chk("R1", "dwr_data", dwr_data, d[7:0]);
        chk("R9", "irq_ibi_ready", irq_rdy, post);
        chk("R8", "swr_valid", swr_valid, post);
        if (post) begin
            chk("R8", "swr_idx", swr_idx, e_idx);
            if (last) chk("R4", "last word", swr_word, e_word);
            else      chk("R5", "split word", swr_word, e_word);
            chk("R6", "err flag", swr_word[30], ne);
            chk("R7", "taddr", swr_word[29:23], na);
        end
        acc = 1'b1;
        #0.5;
    endtask

    task automatic give_back(input int n);
        cr_v = 1'b1; cr_n = 10'(n);
        @(negedge clk);
        cr_v = 1'b0; m_used -= n;
        #0.5;
    endtask

    task automatic resolve();
        if (m_full()) sw_deq = 8'(m_enq);
        else if (m_used > 0) give_back(m_used);
        else begin @(negedge clk); #0.5; end
    endtask

    task automatic payload(input int len, input int a, input int err_pos, input int err_rate);
        for (int i = 0; i < len; i++) begin
            bit acc, e;
            e = (i == err_pos) || (err_rate != 0 && ($urandom % err_rate) == 0);
            do begin
                send(i == 0, i == len - 1, e, a, $urandom % 256, acc);
                if (!acc) resolve();
            end while (!acc);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; code = 3'd0; sw_deq = 8'd0; cr_v = 1'b0; cr_n = '0;
        iv = 1'b0; ist = 1'b0; ilast = 1'b0; ierr = 1'b0; ia = '0; id = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #0.5;
        chk("R11", "in_ready", in_ready, 1);
        chk("R11", "stall", stall, 0);
        chk("R11", "dwr_valid", dwr_valid, 0);
        chk("R11", "swr_valid", swr_valid, 0);
        chk("R11", "irq_ibi_ready", irq_rdy, 0);
        chk("R11", "irq_ring_full", irq_full, 0);

        // R3/R5: 41 bytes of 4-byte chunks drain all credit mid-chunk, split every 4 chunks
        payload(41, 7'h2A, -1, 0);
        sw_deq = 8'(m_enq);
        // R6: error inside one group, next payload clean
        payload(10, 7'h11, 3, 0);
        payload(3, 7'h12, -1, 0);
        // R10: single-byte payloads until the ring fills
        for (int k = 0; k < 8; k++) payload(1, k, -1, 0);
        sw_deq = 8'(m_enq);
        if (m_used > 0) give_back(m_used);

        // Random traffic, several chunk sizes (R1, R2)
        for (int ph = 0; ph < 3; ph++) begin
            code = 3'(ph);
            for (int p = 0; p < 120; p++) begin
                payload(1 + $urandom % 40, $urandom % 128, -1, 9);
                if ($urandom % 3 == 0 && m_used > 0) give_back(1 + $urandom % m_used);
                if ($urandom % 2 == 0) begin
                    int pend;
                    pend = (m_enq - sw_deq + RING) % RING;
                    sw_deq = 8'((sw_deq + $urandom % (pend + 1)) % RING);
                end
            end
        end
        code = 3'd6;
        payload(300, 7'h55, 150, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule